// File: doc/BRIEF.md
# Aligned Register Window Mapper

This block places an eight-word wide register block over a movable eight-word window in a 512-word core register space. A configuration command loads a 9-bit window base. After that, every read address and the write address are decoded against the window. The decode gives a hit flag and the lane (0 to 7) of the wide register block that the access uses. The write strobe goes either to the wide register block or to the normal RAM, never to both.

The window is only active when its base is a multiple of eight. Because of this, the hit test compares the upper six address bits with one stored six-bit tag. It does not need to hold and compare eight separate addresses. If the base is loaded with any of its three low bits set, the window is switched off and every access goes to RAM. The number of read ports is a parameter, and every read port has its own decoder.

Top module: `win_map_top`

## Requirements
- R1: After reset the window is disabled: every read hit flag and the write hit flag are 0, and a write strobe goes only to RAM.
- R2: When the loaded base has bits 2..0 equal to 000, an address hits exactly when its bits 8..3 equal bits 8..3 of the base. Legal bases are 0x000, 0x008, ..., 0x1F8.
- R3: On a hit, the lane output equals address bits 2..0. On a miss, the lane output is 0.
- R4: A base loaded with any of bits 2..0 nonzero disables the window, so no address hits.
- R5: A base loaded in cycle N governs decoding from cycle N+1. An access in cycle N itself is decoded with the previous base.
- R6: Write redirection works as follows. When the write enable is high, `wide_we` equals the write hit and `ram_we` equals its inverse. When the write enable is low, both strobes are 0.
- R7: In cycles without a configuration command, the window state holds unchanged.
- R8: Each read port is decoded independently. Read port k uses bits [9k+8:9k] of `rd_addr`, and its results appear in `rd_hit[k]` and in bits [3k+2:3k] of `rd_lane`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Load a new window base this cycle |
| cfg_base | input | 9 | Window base address |
| rd_addr | input | 18 | Read addresses, one 9-bit field per read port |
| rd_hit | output | 2 | Per read port: the address falls in the window |
| rd_lane | output | 6 | Per read port: 3-bit lane index |
| wr_addr | input | 9 | Write address |
| wr_en | input | 1 | Write request |
| wr_hit | output | 1 | The write address falls in the window |
| wr_lane | output | 3 | Lane index of the write |
| wide_we | output | 1 | Write strobe to the wide register block |
| ram_we | output | 1 | Write strobe to normal RAM |

## Verification
The two functions that can coincide are reloading the window base and decoding an access. They can meet in the same cycle. The bench provokes this by issuing a configuration command while the read and write addresses point into both the old window and the new one. The expected outcome is that the old base decides that cycle and the new base decides the cycle after. The behavioural model updates its stored base only after comparing each cycle, so any early or late switch of the base shows up as a mismatch on the hit and strobe outputs.

// File: rtl/win_map_pkg.sv
package win_map_pkg;
   localparam int unsigned DEF_ADDR_W = 9;
   localparam int unsigned DEF_LANE_W = 3;
   localparam int unsigned DEF_NUM_RD = 2;

   function automatic int unsigned tag_width(input int unsigned addr_w, input int unsigned lane_w);
      return addr_w - lane_w;
   endfunction
endpackage

// File: rtl/win_base_reg.sv
module win_base_reg #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned LANE_W = 3,
   localparam int unsigned TAG_W = ADDR_W - LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   output logic              win_on,
   output logic [TAG_W-1:0]  win_tag
);
   logic aligned;
   assign aligned = (base[LANE_W-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_on  <= 1'b0;
         win_tag <= '0;
      end else if (load) begin
         win_on  <= aligned;
         win_tag <= base[ADDR_W-1:LANE_W];
      end
   end
endmodule

// File: rtl/win_decode.sv
module win_decode #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned LANE_W = 3,
   localparam int unsigned TAG_W = ADDR_W - LANE_W
) (
   input  logic              win_on,
   input  logic [TAG_W-1:0]  win_tag,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [LANE_W-1:0] lane
);
   always_comb begin
      hit  = win_on && (addr[ADDR_W-1:LANE_W] == win_tag);
      lane = hit ? addr[LANE_W-1:0] : '0;
   end
endmodule

// File: rtl/win_map_top.sv
module win_map_top
   import win_map_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned LANE_W = DEF_LANE_W,
   parameter int unsigned NUM_RD = DEF_NUM_RD,
   localparam int unsigned TAG_W = tag_width(ADDR_W, LANE_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_valid,
   input  logic [ADDR_W-1:0]        cfg_base,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   output logic [NUM_RD-1:0]        rd_hit,
   output logic [NUM_RD*LANE_W-1:0] rd_lane,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic                     wr_en,
   output logic                     wr_hit,
   output logic [LANE_W-1:0]        wr_lane,
   output logic                     wide_we,
   output logic                     ram_we
);
   initial begin
      if (LANE_W < 1 || ADDR_W <= LANE_W)
         $fatal(1, "win_map_top: ADDR_W must exceed LANE_W, LANE_W >= 1");
      if (NUM_RD < 1)
         $fatal(1, "win_map_top: NUM_RD must be at least 1");
   end

   logic             win_on;
   logic [TAG_W-1:0] win_tag;

   win_base_reg #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cfg_valid),
      .base    (cfg_base),
      .win_on  (win_on),
      .win_tag (win_tag)
   );

   for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
      win_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dec (
         .win_on  (win_on),
         .win_tag (win_tag),
         .addr    (rd_addr[k*ADDR_W +: ADDR_W]),
         .hit     (rd_hit[k]),
         .lane    (rd_lane[k*LANE_W +: LANE_W])
      );
   end

   win_decode #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_wdec (
      .win_on  (win_on),
      .win_tag (win_tag),
      .addr    (wr_addr),
      .hit     (wr_hit),
      .lane    (wr_lane)
   );

   always_comb begin
      wide_we = wr_en & wr_hit;
      ram_we  = wr_en & ~wr_hit;
   end
endmodule

// File: rtl/win_map_chk.sv
module win_map_chk #(
   parameter int unsigned ADDR_W = 9,
   parameter int unsigned LANE_W = 3,
   parameter int unsigned NUM_RD = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     cfg_valid,
   input logic [ADDR_W-1:0]        cfg_base,
   input logic [NUM_RD-1:0]        rd_hit,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic                     wr_en,
   input logic                     wr_hit,
   input logic [LANE_W-1:0]        wr_lane,
   input logic                     wide_we,
   input logic                     ram_we
);
   logic cfg_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_seen <= 1'b0;
      else if (cfg_valid) cfg_seen <= 1'b1;
   end

   // R1: no hits until the first configuration lands
   p_reset_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_seen |-> (!wr_hit && rd_hit == '0));

   // R4: unaligned base switches the window off
   p_unaligned_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_base[LANE_W-1:0] != '0) |=> (!wr_hit && rd_hit == '0));

   // R5 / R2: aligned base decides the next cycle's write hit
   p_apply_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_base[LANE_W-1:0] == '0) |=>
         (wr_hit == (wr_addr[ADDR_W-1:LANE_W] == $past(cfg_base[ADDR_W-1:LANE_W]))));

   // R3: lane follows low address bits on hit, zero on miss
   p_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit ? (wr_lane == wr_addr[LANE_W-1:0]) : (wr_lane == '0));

   // R6: strobes are exclusive and follow the request
   p_write_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wide_we && ram_we) && ((wide_we || ram_we) == wr_en));

   // R7: without configuration, a hit on an unchanged address stays a hit
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_valid && wr_hit) |=> (wr_hit || wr_addr != $past(wr_addr)));
endmodule

bind win_map_top win_map_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .NUM_RD(NUM_RD)) i_win_map_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_valid (cfg_valid),
   .cfg_base  (cfg_base),
   .rd_hit    (rd_hit),
   .wr_addr   (wr_addr),
   .wr_en     (wr_en),
   .wr_hit    (wr_hit),
   .wr_lane   (wr_lane),
   .wide_we   (wide_we),
   .ram_we    (ram_we)
);

// File: tb/test_win_map_top.sv
`timescale 1ns/1ps
module test_win_map_top;
   localparam int AW = 9;
   localparam int LW = 3;
   localparam int NR = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_valid = 1'b0;
   logic [AW-1:0]   cfg_base = '0;
   logic [NR*AW-1:0] rd_addr = '0;
   logic [NR-1:0]   rd_hit;
   logic [NR*LW-1:0] rd_lane;
   logic [AW-1:0]   wr_addr = '0;
   logic            wr_en = 1'b0;
   logic            wr_hit;
   logic [LW-1:0]   wr_lane;
   logic            wide_we;
   logic            ram_we;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   // model state
   bit      m_on = 0;
   int      m_tag = 0;

   always #5 clk = ~clk;

   win_map_top i_win_map_top (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_base(cfg_base),
      .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_lane(rd_lane),
      .wr_addr(wr_addr), .wr_en(wr_en), .wr_hit(wr_hit), .wr_lane(wr_lane),
      .wide_we(wide_we), .ram_we(ram_we)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic cmp(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic bit m_hit(input int a);
      return m_on && ((a >> 3) == m_tag);
   endfunction

   // One clock cycle: drive at negedge, compare before posedge, update model.
   task automatic step(input bit cv, input int cb, input int ra0, input int ra1,
                       input int wa, input bit we, input string tag);
      int ra[2];
      @(negedge clk);
      cfg_valid = cv; cfg_base = AW'(cb);
      rd_addr = {AW'(ra1), AW'(ra0)};
      wr_addr = AW'(wa); wr_en = we;
      ra[0] = ra0; ra[1] = ra1;
      #2;
      for (int k = 0; k < NR; k++) begin
         bit h;
         h = m_hit(ra[k]);
         cmp({tag, " R2/R8 rd_hit"}, int'(rd_hit[k]), int'(h));
         cmp({tag, " R3/R8 rd_lane"}, int'(rd_lane[k*LW +: LW]), h ? (ra[k] & 7) : 0);
      end
      cmp({tag, " R2 wr_hit"}, int'(wr_hit), int'(m_hit(wa)));
      cmp({tag, " R3 wr_lane"}, int'(wr_lane), m_hit(wa) ? (wa & 7) : 0);
      cmp({tag, " R6 wide_we"}, int'(wide_we), int'(we && m_hit(wa)));
      cmp({tag, " R6 ram_we"}, int'(ram_we), int'(we && !m_hit(wa)));
      if (cv) begin
         m_on  = ((cb & 7) == 0);
         m_tag = (cb >> 3) & 63;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      // R1: reset state, window off
      step(0, 0, 0, 8, 0, 1, "R1 reset");
      @(negedge clk); rst_n = 1'b1;
      step(0, 0, 0, 5, 3, 1, "R1 after reset");

      // R2 aligned base 0x008, sweep write address through neighbourhood
      step(1, 'h008, 0, 0, 0, 0, "R2 cfg 0x008");
      for (int a = 0; a < 24; a++) step(0, 0, a, 23 - a, a, a[0], "R2 sweep 0x008");

      // R2 top window 0x1F8
      step(1, 'h1F8, 0, 0, 0, 0, "R2 cfg 0x1F8");
      for (int a = 'h1F0; a < 'h200; a++) step(0, 0, a, 'h1FF, a, 1, "R2 sweep 0x1F8");

      // R4 unaligned base disables
      step(1, 'h009, 0, 0, 0, 0, "R4 cfg 0x009");
      for (int a = 0; a < 20; a++) step(0, 0, a, a + 'h1F0, a, 1, "R4 off");
      step(1, 'h1FF, 0, 0, 0, 0, "R4 cfg 0x1FF");
      step(0, 0, 'h1F8, 'h1FF, 'h1FB, 1, "R4 off top");

      // R5 same-cycle config and access: old base 0x000 decides this cycle
      step(1, 'h000, 0, 0, 0, 0, "R5 cfg 0x000");
      step(1, 'h040, 'h003, 'h041, 'h002, 1, "R5 same cycle");
      step(0, 0, 'h003, 'h041, 'h042, 1, "R5 next cycle");
      step(1, 'h00C, 'h040, 'h047, 'h045, 1, "R5 to unaligned");
      step(0, 0, 'h040, 'h047, 'h045, 1, "R5 off after");

      // R7 holding: base 0x100 kept over idle cycles
      step(1, 'h100, 0, 0, 0, 0, "R7 cfg 0x100");
      for (int i = 0; i < 10; i++) step(0, 'h000, 'h100 + i, 'h107, 'h104, i[0], "R7 hold");

      // mixed pseudo-random traffic
      for (int i = 0; i < 400; i++) begin
         int b;
         b = $urandom_range(0, 511);
         if ($urandom_range(0, 3) != 0) b = b & 'h1F8;
         step($urandom_range(0, 5) == 0, b,
              $urandom_range(0, 511), $urandom_range(0, 511),
              $urandom_range(0, 511), $urandom_range(0, 1), "R2/R5/R8 mixed");
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule